// File: doc/BRIEF.md
# Image Sensor Column Readout Sequencer

This block sequences the readout of one row of an image sensor whose pixel columns feed an external 10-bit ADC. A single-cycle row request supplies a start column and a pixel count. The block then places the column address on the sensor's address bus and waits a setup interval. It pulses the address load strobe, then runs the column shift clock. The sensor's output amplifier is pipelined, so the pixel that was addressed first reaches the analog output only on the third rising edge of the column clock. The first column-clock periods therefore only fill that pipeline, and the ADC is not clocked during them.

Once the pipeline is full, each column-clock period carries one pixel. The ADC clock is high during the first half of the period. Its falling edge starts a conversion in the middle of the period, after the analog level has settled. The digital result appears on the data bus a fixed delay later. The block samples the bus on the first system cycle at which the result is valid. It emits the sample as a one-cycle pixel pulse that carries first and last markers. All sensor timing is set by parameters counted in system clock cycles. A request that would run past the last column of the line is shortened so that it ends at that column, and an error flag reports the shortening.

Top module: `col_readout_seq`

## Requirements
- R1: A `rowStart` pulse seen while the block is idle, with `pixCount` nonzero, starts a row. `busy` is high from the next cycle for exactly SETUP_CYC + HOLD_CYC + (PRIME_SLOTS + n) * 2 * COL_HALF + 1 cycles, where n is the effective pixel count. With the default parameters this is 53 + 16n cycles.
- R2: A `rowStart` that arrives while `busy` is high is ignored, and so is one with `pixCount` equal to zero. Neither changes the address, the flag or the strobe sequence.
- R3: From the cycle after acceptance, `colAddr` carries the start column and holds it for the whole row. `loadStrobe` rises SETUP_CYC + 1 cycles after that cycle and stays high for HOLD_CYC cycles.
- R4: When `loadStrobe` falls, `colClk` begins. It runs PRIME_SLOTS + n periods of 2 * COL_HALF cycles each, high for the first COL_HALF cycles of every period. It is low at all other times.
- R5: `adcClk` is low during the PRIME_SLOTS pipeline-fill periods. In each of the following n periods it is high for the first COL_HALF cycles, so it falls in the middle of the period.
- R6: `adcData` is sampled exactly ADC_DLY cycles after the cycle in which `adcClk` goes low. `pixValid` pulses for that one cycle, and `pixData` holds the sample until the next pulse.
- R7: A row gives exactly n `pixValid` pulses, one per period. Pulse k carries the conversion of column start + k.
- R8: `pixFirst` is high only with the first pulse of a row, and `pixLast` only with the last. A row with one pixel has both flags on the same pulse.
- R9: If start + `pixCount` exceeds 1024, n becomes 1024 - start and `rangeErr` goes high from the cycle after acceptance. The next accepted request that fits clears `rangeErr`.
- R10: After the last period the block is idle again. A `rowStart` held high is accepted again in the first cycle in which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rowStart | input | 1 | Row request |
| startCol | input | 10 | First column of the row |
| pixCount | input | 11 | Requested pixel count (1 to 1024) |
| adcData | input | 10 | ADC result bus |
| colAddr | output | 10 | Column address to the sensor |
| loadStrobe | output | 1 | Address load strobe; rising edge latches colAddr |
| colClk | output | 1 | Column shift clock |
| adcClk | output | 1 | ADC conversion clock; falling edge starts a conversion |
| pixData | output | 10 | Captured pixel value |
| pixValid | output | 1 | One-cycle pulse per captured pixel |
| pixFirst | output | 1 | Marks the first pixel of a row |
| pixLast | output | 1 | Marks the last pixel of a row |
| busy | output | 1 | High while a row is in progress |
| rangeErr | output | 1 | The last accepted request was shortened at the line end |

## Verification
The bench's ADC model drives the correct value on the data bus for one cycle only, exactly ADC_DLY cycles after each falling edge. At every other time the bus carries a corrupted value. A capture that comes one cycle early or late, or a conversion started during the pipeline-fill periods, therefore produces a wrong pixel value or shifts the column sequence.

The bench drives requests at both ends of the line. It ends a row exactly at column 1023, runs past the end to trigger shortening, and reads the full line from column 0. A design that clamped off by one would emit one pixel too many or too few and set `rangeErr` wrongly.

It also issues requests while `busy` is high, a request with a count of zero, and a `rowStart` held high through several rows. These catch a design that restarts in the middle of a row or loses a cycle when it returns to idle.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOAD,
    ST_PRIME,
    ST_READ,
    ST_DONE
  } seqState_t;

  // Strobes from control to datapath, one cycle ahead of the pins.
  typedef struct packed {
    logic latchReq;   // capture start column and error status
    logic clampHit;   // request was shortened at line end
    logic loadOn;     // address load strobe level
    logic colOn;      // column clock level
    logic adcOn;      // ADC clock level
    logic capture;    // sample the ADC bus on this edge
    logic firstPix;   // captured pixel is the first of the row
    logic lastPix;    // captured pixel is the last of the row
  } crsStrobe_t;

endpackage

// File: rtl/crs_ctrl.sv
module crs_ctrl
  import crs_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SETUP_CYC   = 10,
  parameter int HOLD_CYC    = 10,
  parameter int COL_HALF    = 8,
  parameter int ADC_DLY     = 5,
  parameter int PRIME_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowStart,
  input  logic [ADDR_W-1:0] startCol,
  input  logic [ADDR_W:0]   pixCount,
  output logic              busy,
  output crsStrobe_t        stb
);

  localparam int CNT_W    = ADDR_W + 1;
  localparam int SLOT_CYC = 2 * COL_HALF;
  localparam int MAX_SH   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int TICK_MAX = (MAX_SH > SLOT_CYC) ? MAX_SH : SLOT_CYC;
  localparam int TICK_W   = $clog2(TICK_MAX + 1);
  localparam int PRIME_W  = $clog2(PRIME_SLOTS + 1);

  localparam logic [TICK_W-1:0]  SETUP_LAST = TICK_W'(SETUP_CYC - 1);
  localparam logic [TICK_W-1:0]  HOLD_LAST  = TICK_W'(HOLD_CYC - 1);
  localparam logic [TICK_W-1:0]  SLOT_LAST  = TICK_W'(SLOT_CYC - 1);
  localparam logic [TICK_W-1:0]  HALF_TICK  = TICK_W'(COL_HALF);
  localparam logic [TICK_W-1:0]  CAPT_TICK  = TICK_W'(COL_HALF + ADC_DLY);
  localparam logic [PRIME_W-1:0] PRIME_LAST = PRIME_W'(PRIME_SLOTS - 1);
  localparam logic [CNT_W-1:0]   LINE_PIX   = {1'b1, {ADDR_W{1'b0}}};

  seqState_t          state;
  logic [TICK_W-1:0]  tick;
  logic [PRIME_W-1:0] primeIdx;
  logic [CNT_W-1:0]   pixIdx;
  logic [CNT_W-1:0]   numPix;

  logic              accept;
  logic [CNT_W-1:0]  room;
  logic              overRun;
  logic [CNT_W-1:0]  lastIdx;
  logic              slotEnd;

  assign room    = LINE_PIX - {1'b0, startCol};
  assign overRun = pixCount > room;
  assign accept  = (state == ST_IDLE) && rowStart && (pixCount != '0);
  assign lastIdx = numPix - CNT_W'(1);
  assign slotEnd = (tick == SLOT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tick     <= '0;
      primeIdx <= '0;
      pixIdx   <= '0;
      numPix   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_SETUP;
            tick   <= '0;
            numPix <= overRun ? room : pixCount;
          end
        end
        ST_SETUP: begin
          if (tick == SETUP_LAST) begin
            state <= ST_LOAD;
            tick  <= '0;
          end else begin
            tick <= tick + TICK_W'(1);
          end
        end
        ST_LOAD: begin
          if (tick == HOLD_LAST) begin
            state    <= ST_PRIME;
            tick     <= '0;
            primeIdx <= '0;
          end else begin
            tick <= tick + TICK_W'(1);
          end
        end
        ST_PRIME: begin
          if (slotEnd) begin
            tick <= '0;
            if (primeIdx == PRIME_LAST) begin
              state  <= ST_READ;
              pixIdx <= '0;
            end else begin
              primeIdx <= primeIdx + PRIME_W'(1);
            end
          end else begin
            tick <= tick + TICK_W'(1);
          end
        end
        ST_READ: begin
          if (slotEnd) begin
            tick <= '0;
            if (pixIdx == lastIdx) begin
              state <= ST_DONE;
            end else begin
              pixIdx <= pixIdx + CNT_W'(1);
            end
          end else begin
            tick <= tick + TICK_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.latchReq = accept;
    stb.clampHit = accept && overRun;
    stb.loadOn   = (state == ST_LOAD);
    stb.colOn    = ((state == ST_PRIME) || (state == ST_READ)) && (tick < HALF_TICK);
    stb.adcOn    = (state == ST_READ) && (tick < HALF_TICK);
    stb.capture  = (state == ST_READ) && (tick == CAPT_TICK);
    stb.firstPix = stb.capture && (pixIdx == '0);
    stb.lastPix  = stb.capture && (pixIdx == lastIdx);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/crs_datapath.sv
module crs_datapath
  import crs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  crsStrobe_t        stb,
  input  logic [ADDR_W-1:0] startCol,
  input  logic [DATA_W-1:0] adcData,
  output logic [ADDR_W-1:0] colAddr,
  output logic              rangeErr,
  output logic              loadStrobe,
  output logic              colClk,
  output logic              adcClk,
  output logic [DATA_W-1:0] pixData,
  output logic              pixValid,
  output logic              pixFirst,
  output logic              pixLast
);

  // Request capture: address and shortening status.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colAddr  <= '0;
      rangeErr <= 1'b0;
    end else if (stb.latchReq) begin
      colAddr  <= startCol;
      rangeErr <= stb.clampHit;
    end
  end

  // Sensor-facing clocks leave from flops so the pins are glitch free.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadStrobe <= 1'b0;
      colClk     <= 1'b0;
      adcClk     <= 1'b0;
    end else begin
      loadStrobe <= stb.loadOn;
      colClk     <= stb.colOn;
      adcClk     <= stb.adcOn;
    end
  end

  // Sample capture and pixel stream.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixData  <= '0;
      pixValid <= 1'b0;
      pixFirst <= 1'b0;
      pixLast  <= 1'b0;
    end else begin
      pixValid <= stb.capture;
      pixFirst <= stb.firstPix;
      pixLast  <= stb.lastPix;
      if (stb.capture) pixData <= adcData;
    end
  end

endmodule

// File: rtl/col_readout_seq.sv
module col_readout_seq
  import crs_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 10,
  parameter int SETUP_CYC   = 10,
  parameter int HOLD_CYC    = 10,
  parameter int COL_HALF    = 8,
  parameter int ADC_DLY     = 5,
  parameter int PRIME_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowStart,
  input  logic [ADDR_W-1:0] startCol,
  input  logic [ADDR_W:0]   pixCount,
  input  logic [DATA_W-1:0] adcData,
  output logic [ADDR_W-1:0] colAddr,
  output logic              loadStrobe,
  output logic              colClk,
  output logic              adcClk,
  output logic [DATA_W-1:0] pixData,
  output logic              pixValid,
  output logic              pixFirst,
  output logic              pixLast,
  output logic              busy,
  output logic              rangeErr
);

  crsStrobe_t stb;

  crs_ctrl #(
    .ADDR_W     (ADDR_W),
    .SETUP_CYC  (SETUP_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .COL_HALF   (COL_HALF),
    .ADC_DLY    (ADC_DLY),
    .PRIME_SLOTS(PRIME_SLOTS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rowStart(rowStart),
    .startCol(startCol),
    .pixCount(pixCount),
    .busy    (busy),
    .stb     (stb)
  );

  crs_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .startCol  (startCol),
    .adcData   (adcData),
    .colAddr   (colAddr),
    .rangeErr  (rangeErr),
    .loadStrobe(loadStrobe),
    .colClk    (colClk),
    .adcClk    (adcClk),
    .pixData   (pixData),
    .pixValid  (pixValid),
    .pixFirst  (pixFirst),
    .pixLast   (pixLast)
  );

endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int ADDR_W    = 10,
  parameter int SETUP_CYC = 10,
  parameter int ADC_DLY   = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              rowStart,
  input logic [ADDR_W-1:0] colAddr,
  input logic              loadStrobe,
  input logic              colClk,
  input logic              adcClk,
  input logic              pixValid,
  input logic              pixFirst,
  input logic              pixLast,
  input logic              busy
);

  localparam int AGE_W  = $clog2(SETUP_CYC + 2);
  localparam int FALL_W = $clog2(ADC_DLY + 3);
  localparam logic [AGE_W-1:0]  AGE_SAT  = AGE_W'(SETUP_CYC);
  localparam logic [FALL_W-1:0] FALL_SAT = FALL_W'(ADC_DLY + 1);
  localparam logic [FALL_W-1:0] FALL_HIT = FALL_W'(ADC_DLY);

  logic [ADDR_W-1:0] addrPrev;
  logic [AGE_W-1:0]  addrAge;
  logic              adcPrev;
  logic [FALL_W-1:0] fallAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPrev <= '0;
      addrAge  <= '0;
      adcPrev  <= 1'b0;
      fallAge  <= FALL_SAT;
    end else begin
      addrPrev <= colAddr;
      if (colAddr != addrPrev) addrAge <= '0;
      else if (addrAge != AGE_SAT) addrAge <= addrAge + AGE_W'(1);
      adcPrev <= adcClk;
      if (adcPrev && !adcClk) fallAge <= FALL_W'(1);
      else if (fallAge != FALL_SAT) fallAge <= fallAge + FALL_W'(1);
    end
  end

  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadStrobe) |-> (addrAge >= AGE_SAT)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> $stable(colAddr)); // R3
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rowStart) |=> $stable(colAddr)); // R2
  AST_COL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !(loadStrobe && colClk)); // R4
  AST_ADC_IN_ROW: assert property (@(posedge clk) disable iff (!rstN)
    adcClk |-> (busy && !loadStrobe)); // R5
  AST_CAPTURE_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (fallAge == FALL_HIT)); // R6
  AST_SINGLE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid); // R7
  AST_FLAG_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    (pixFirst || pixLast) |-> pixValid); // R8
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> busy); // R1

endmodule

bind col_readout_seq crs_checker #(
  .ADDR_W   (ADDR_W),
  .SETUP_CYC(SETUP_CYC),
  .ADC_DLY  (ADC_DLY)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rowStart  (rowStart),
  .colAddr   (colAddr),
  .loadStrobe(loadStrobe),
  .colClk    (colClk),
  .adcClk    (adcClk),
  .pixValid  (pixValid),
  .pixFirst  (pixFirst),
  .pixLast   (pixLast),
  .busy      (busy)
);

// File: tb/tb_col_readout_seq.sv
module tb_col_readout_seq;

  localparam int SETUP_CYC   = 10;
  localparam int HOLD_CYC    = 10;
  localparam int COL_HALF    = 8;
  localparam int ADC_DLY     = 5;
  localparam int PRIME_SLOTS = 2;
  localparam int SLOT        = 2 * COL_HALF;
  localparam int P0          = SETUP_CYC + HOLD_CYC + PRIME_SLOTS * SLOT;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rowStart = 1'b0;
  logic [9:0] startCol = '0;
  logic [10:0] pixCount = '0;
  logic [9:0] adcData = '0;
  logic [9:0] colAddr, pixData;
  logic       loadStrobe, colClk, adcClk, pixValid, pixFirst, pixLast, busy, rangeErr;

  always #2 clk = ~clk;

  col_readout_seq dut (
    .clk(clk), .rstN(rstN), .rowStart(rowStart), .startCol(startCol),
    .pixCount(pixCount), .adcData(adcData), .colAddr(colAddr),
    .loadStrobe(loadStrobe), .colClk(colClk), .adcClk(adcClk),
    .pixData(pixData), .pixValid(pixValid), .pixFirst(pixFirst),
    .pixLast(pixLast), .busy(busy), .rangeErr(rangeErr)
  );

  int  compared = 0;
  int  mismatched = 0;
  bit  finished = 0;

  // Reference model state
  int  cyc = 0;
  bit  haveRow = 0;
  int  tr = 0;
  int  rowN = 0;
  int  rowCol = 0;
  bit  rowErr = 0;
  int  convIdx = 0;
  int  convCol = 0;
  int  adcCd = -1;
  bit  adcPrev = 0;

  function automatic logic [9:0] pixVal(int col);
    return 10'((col * 37 + 11) % 1024);
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      int q, k;
      bit bE, lE, cE, aE, vE;
      bE = 0; lE = 0; cE = 0; aE = 0; vE = 0; k = 0;
      if (haveRow) begin
        q  = cyc - tr - 2;
        bE = (cyc >= tr + 1) && (cyc <= tr + P0 + rowN * SLOT + 1);
        lE = (q >= SETUP_CYC) && (q < SETUP_CYC + HOLD_CYC);
        cE = (q >= SETUP_CYC + HOLD_CYC) && (q < P0 + rowN * SLOT) &&
             (((q - SETUP_CYC - HOLD_CYC) % SLOT) < COL_HALF);
        aE = (q >= P0) && (q < P0 + rowN * SLOT) && (((q - P0) % SLOT) < COL_HALF);
        if (q >= P0) begin
          k  = (q - P0) / SLOT;
          vE = (k < rowN) && (((q - P0) % SLOT) == COL_HALF + ADC_DLY);
        end
      end
      check("R1 R10 busy", int'(busy), int'(bE));
      check("R2 R3 colAddr", int'(colAddr), haveRow ? rowCol : 0);
      check("R3 loadStrobe", int'(loadStrobe), int'(lE));
      check("R4 colClk", int'(colClk), int'(cE));
      check("R5 adcClk", int'(adcClk), int'(aE));
      check("R6 pixValid", int'(pixValid), int'(vE));
      check("R8 pixFirst", int'(pixFirst), int'(vE && k == 0));
      check("R8 pixLast", int'(pixLast), int'(vE && k == rowN - 1));
      check("R9 rangeErr", int'(rangeErr), int'(rowErr));
      if (vE) check("R7 pixData", int'(pixData), int'(pixVal(rowCol + k)));

      // ADC model: result valid for one cycle, ADC_DLY cycles after the fall
      if (rstN) begin
        if (adcPrev && !adcClk) begin
          convCol = rowCol + convIdx;
          convIdx++;
          adcCd = ADC_DLY - 1;
        end else if (adcCd >= 0) begin
          adcCd--;
        end
        adcData = (adcCd == 0) ? pixVal(convCol) : (pixVal(convCol) ^ 10'h155);
        adcPrev = adcClk;

        if (rowStart && pixCount != 0 && !bE) begin
          haveRow = 1;
          tr      = cyc;
          rowCol  = int'(startCol);
          if (int'(startCol) + int'(pixCount) > 1024) begin
            rowN   = 1024 - int'(startCol);
            rowErr = 1;
          end else begin
            rowN   = int'(pixCount);
            rowErr = 0;
          end
          convIdx = 0;
        end
        cyc++;
      end
    end
  end

  task automatic req(int col, int cnt);
    @(posedge clk); #1;
    startCol = 10'(col);
    pixCount = 11'(cnt);
    rowStart = 1'b1;
    @(posedge clk); #1;
    rowStart = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (3) @(posedge clk);
    while (busy) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(posedge clk);
    req(0, 4);               // R1 R3 R4 R5 R6 R7 R8 basic row
    waitIdle();
    req(100, 1);             // R8 single pixel carries both flags
    waitIdle();
    req(1020, 10);           // R9 shortened to 4 pixels
    repeat (30) @(posedge clk);
    req(5, 3);               // R2 ignored while busy
    waitIdle();
    req(1023, 1);            // R9 fits exactly, flag clears
    waitIdle();
    req(50, 0);              // R2 zero count ignored
    repeat (10) @(posedge clk);
    req(0, 1024);            // R7 full line
    waitIdle();
    req(900, 200);           // R9 shortened to 124
    waitIdle();
    @(posedge clk); #1;      // R10 held request re-accepted at idle
    startCol = 10'd200;
    pixCount = 11'd2;
    rowStart = 1'b1;
    repeat (200) @(posedge clk);
    #1 rowStart = 1'b0;
    waitIdle();
    finish();
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog expired actual=busy expected=done");
    finish();
  end

endmodule